// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable model of a 1-Kbit serial EEPROM that sits behind a three-wire serial port: an active-high select, a serial clock and a serial data input, plus a data output with a separate drive-enable that stands in for a tri-state pin. The array holds 64 words of 16 bits. The serial inputs are brought into the system clock domain through synchronisers, and the serial clock is edge-detected there. An instruction is a start bit, a two-bit opcode, a six-bit address and, for the two storing commands, a sixteen-bit data word.

Programming commands do not execute while the frame is being shifted in. They execute when select falls after a complete frame. The model then runs a self-timed program cycle, counted in system clocks, which needs no further serial clock edges. While the cycle runs, a controller can raise select and watch the data output: it reads 0 while the cycle is busy and 1 once it is ready. The model also flags a select that was held low for less than a minimum number of system clocks. A debug read port exposes any word of the array so its contents can be checked.

Top module: `mw_eeprom`

## Requirements
- R1: A single-word store is shifted in as the start bit 1, opcode 01, the address (A5 first) and then the data (D15 first). After the program cycle the addressed word holds that data.
- R2: A program cycle starts only on the falling edge of select that follows a complete programming frame. When select is raised right afterwards, the data output reads busy.
- R3: If select returns high after fewer than T_CSMIN system clocks low, `cs_short_o` goes to 1. It stays at 1 until select next falls, and a long enough low time leaves it at 0.
- R4: The program cycle lasts T_PROG system clocks with the serial clock idle. At the end, the data output reads ready.
- R5: While select is high, the data output is driven, with 0 meaning busy and 1 meaning ready. While select is low, the output is not driven (`dout_en_o` is 0).
- R6: A single-word store first sets the addressed word to all ones when the cycle starts, and stores the data when the cycle ends.
- R7: Opcode 11 with an address sets that word to 0xFFFF and leaves every other word unchanged.
- R8: Opcode 00 with address bits A5:A4 = 10 sets every word to 0xFFFF.
- R9: Opcode 00 with A5:A4 = 01, followed by a data word, stores that word into every location. There is no clear phase, so the old contents stay visible during the cycle.
- R10: Opcode 00 with A5:A4 = 11 enables programming, and with A5:A4 = 00 disables it. Programming is disabled after reset. While it is disabled, programming frames start no cycle and change no word.
- R11: A frame that completes while a program cycle is running is ignored.
- R12: After reset every word reads 0xFFFF, no cycle is running, the output is not driven and `cs_short_o` is 0.
- R13: Serial clock edges with data 0 before the start bit are skipped and do not count as frame bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Serial select, active high |
| sclk_i | input | 1 | Serial clock, sampled on its rising edge |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Ready (1) / busy (0) status |
| dout_en_o | output | 1 | Drive enable for dout_o |
| cs_short_o | output | 1 | Select low time was shorter than T_CSMIN |
| dbg_addr_i | input | 6 | Debug read address |
| dbg_data_o | output | 16 | Debug read data |

## Verification
The assertions assume that the serial inputs change slowly relative to the system clock. Each serial clock phase must last at least two system clocks, and data in must be stable across every rising serial clock edge, so the synchronised copies line up. They also assume a cycle can only begin a few clocks after reset. The bench drives every input on the falling system clock edge. It keeps each serial clock phase at two system clocks, sets data in one full phase before the rising edge, and holds select low for twenty clocks between frames, except in the one test that deliberately shortens it.

// File: rtl/mw_pkg.sv
package mw_pkg;
  typedef enum logic [1:0] {SH_IDLE, SH_HDR, SH_DATA, SH_DONE} sh_state_e;
  typedef enum logic [1:0] {JOB_WRITE, JOB_ERASE, JOB_ERAL, JOB_WRAL} job_e;
  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_ERASE = 2'b11;
  localparam logic [1:0] EXT_EWDS = 2'b00;
  localparam logic [1:0] EXT_WRAL = 2'b01;
  localparam logic [1:0] EXT_ERAL = 2'b10;
  localparam logic [1:0] EXT_EWEN = 2'b11;
endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else if (s == 0) stg[s] <= d_i;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/mw_shifter.sv
module mw_shifter
  import mw_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          sclk_rise_i,
  input  logic          din_i,
  output logic          done_o,
  output logic [1:0]    op_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  localparam int HW = AW + 2;
  localparam int CW = $clog2(DW + 1);

  sh_state_e     state_q;
  logic [HW-1:0] hdr_q, hdr_nxt;
  logic [DW-1:0] data_q;
  logic [CW-1:0] cnt_q;
  logic          need_data;

  assign hdr_nxt   = {hdr_q[HW-2:0], din_i};
  assign need_data = (hdr_nxt[HW-1 -: 2] == OP_WRITE) ||
                     (hdr_nxt[HW-1 -: 2] == OP_EXT && hdr_nxt[AW-1 -: 2] == EXT_WRAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SH_IDLE;
      hdr_q   <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
    end else if (!cs_i) begin
      state_q <= SH_IDLE;
    end else if (sclk_rise_i) begin
      unique case (state_q)
        SH_IDLE: if (din_i) begin
          state_q <= SH_HDR;
          cnt_q   <= '0;
          hdr_q   <= '0;
          data_q  <= '0;
        end
        SH_HDR: begin
          hdr_q <= hdr_nxt;
          if (cnt_q == CW'(HW-1)) begin
            cnt_q   <= '0;
            state_q <= need_data ? SH_DATA : SH_DONE;
          end else cnt_q <= cnt_q + 1'b1;
        end
        SH_DATA: begin
          data_q <= {data_q[DW-2:0], din_i};
          if (cnt_q == CW'(DW-1)) state_q <= SH_DONE;
          else cnt_q <= cnt_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign done_o = (state_q == SH_DONE);
  assign op_o   = hdr_q[HW-1 -: 2];
  assign addr_o = hdr_q[AW-1:0];
  assign data_o = data_q;
endmodule

// File: rtl/mw_ctrl.sv
module mw_ctrl
  import mw_pkg::*;
#(
  parameter int AW      = 6,
  parameter int DW      = 16,
  parameter int T_PROG  = 300,
  parameter int T_CSMIN = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          done_i,
  input  logic [1:0]    op_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          wen_o,
  output logic          cs_short_o,
  output logic [AW-1:0] job_addr_o,
  output logic          wr_one_o,
  output logic          wr_all_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int TW = $clog2(T_PROG + 1);
  localparam int LW = $clog2(T_CSMIN + 1);

  logic          cs_q, cs_fall, cs_rise, accept, start;
  logic [1:0]    ext;
  logic [TW-1:0] timer_q;
  logic [LW-1:0] low_q;
  job_e          job_q, job_d;
  logic [DW-1:0] jdata_q;
  logic          prog_cmd, finish;

  assign cs_fall = cs_q & ~cs_i;
  assign cs_rise = ~cs_q & cs_i;
  assign accept  = cs_fall & done_i & ~busy_o;
  assign ext     = addr_i[AW-1 -: 2];

  always_comb begin
    prog_cmd = 1'b0;
    job_d    = JOB_WRITE;
    unique case (op_i)
      OP_WRITE: prog_cmd = 1'b1;
      OP_ERASE: begin prog_cmd = 1'b1; job_d = JOB_ERASE; end
      OP_EXT: begin
        if (ext == EXT_ERAL) begin prog_cmd = 1'b1; job_d = JOB_ERAL; end
        if (ext == EXT_WRAL) begin prog_cmd = 1'b1; job_d = JOB_WRAL; end
      end
      default: ;
    endcase
  end

  assign start  = accept & prog_cmd & wen_o;
  assign finish = busy_o & (timer_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q       <= 1'b0;
      busy_o     <= 1'b0;
      wen_o      <= 1'b0;
      timer_q    <= '0;
      job_q      <= JOB_WRITE;
      job_addr_o <= '0;
      jdata_q    <= '0;
      low_q      <= LW'(T_CSMIN);
      cs_short_o <= 1'b0;
    end else begin
      cs_q <= cs_i;
      // select low-time watch
      if (cs_i) low_q <= '0;
      else if (low_q != LW'(T_CSMIN)) low_q <= low_q + 1'b1;
      if (cs_fall) cs_short_o <= 1'b0;
      else if (cs_rise) cs_short_o <= (low_q < LW'(T_CSMIN));
      // enable latch
      if (accept && op_i == OP_EXT) begin
        if (ext == EXT_EWEN) wen_o <= 1'b1;
        if (ext == EXT_EWDS) wen_o <= 1'b0;
      end
      if (start) begin
        busy_o     <= 1'b1;
        timer_q    <= TW'(T_PROG - 1);
        job_q      <= job_d;
        job_addr_o <= addr_i;
        jdata_q    <= data_i;
      end else if (finish) begin
        busy_o <= 1'b0;
      end else if (busy_o) begin
        timer_q <= timer_q - 1'b1;
      end
    end
  end

  // array write port: clear at start of WRITE, commit at end of cycle
  always_comb begin
    wr_one_o  = 1'b0;
    wr_all_o  = 1'b0;
    wr_addr_o = job_addr_o;
    wr_data_o = '1;
    if (start && job_d == JOB_WRITE) begin
      wr_one_o  = 1'b1;
      wr_addr_o = addr_i;
    end else if (finish) begin
      unique case (job_q)
        JOB_WRITE: begin wr_one_o = 1'b1; wr_data_o = jdata_q; end
        JOB_ERASE: wr_one_o = 1'b1;
        JOB_ERAL:  wr_all_o = 1'b1;
        JOB_WRAL:  begin wr_all_o = 1'b1; wr_data_o = jdata_q; end
      endcase
    end
  end
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_one_i,
  input  logic          wr_all_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mem[w] <= '1;
      else if (wr_all_i || (wr_one_i && wr_addr_i == AW'(w))) mem[w] <= wr_data_i;
    end
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int AW      = 6,
  parameter int DW      = 16,
  parameter int T_PROG  = 300,
  parameter int T_CSMIN = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_i,
  input  logic          sclk_i,
  input  logic          din_i,
  output logic          dout_o,
  output logic          dout_en_o,
  output logic          cs_short_o,
  input  logic [AW-1:0] dbg_addr_i,
  output logic [DW-1:0] dbg_data_o
);
  logic          cs_s, sclk_s, din_s, sclk_q, sclk_rise;
  logic          done, busy, wen, wr_one, wr_all;
  logic [1:0]    op;
  logic [AW-1:0] addr, job_addr, wr_addr;
  logic [DW-1:0] data, wr_data;

  mw_sync #(.W(3), .STAGES(2)) i_sync (
    .clk_i, .rst_ni,
    .d_i ({cs_i, sclk_i, din_i}),
    .q_o ({cs_s, sclk_s, din_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b0;
    else sclk_q <= sclk_s;
  end
  assign sclk_rise = sclk_s & ~sclk_q;

  mw_shifter #(.AW(AW), .DW(DW)) i_shifter (
    .clk_i, .rst_ni,
    .cs_i        (cs_s),
    .sclk_rise_i (sclk_rise),
    .din_i       (din_s),
    .done_o      (done),
    .op_o        (op),
    .addr_o      (addr),
    .data_o      (data)
  );

  mw_ctrl #(.AW(AW), .DW(DW), .T_PROG(T_PROG), .T_CSMIN(T_CSMIN)) i_ctrl (
    .clk_i, .rst_ni,
    .cs_i       (cs_s),
    .done_i     (done),
    .op_i       (op),
    .addr_i     (addr),
    .data_i     (data),
    .busy_o     (busy),
    .wen_o      (wen),
    .cs_short_o (cs_short_o),
    .job_addr_o (job_addr),
    .wr_one_o   (wr_one),
    .wr_all_o   (wr_all),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data)
  );

  mw_array #(.AW(AW), .DW(DW)) i_array (
    .clk_i, .rst_ni,
    .wr_one_i  (wr_one),
    .wr_all_i  (wr_all),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .rd_addr_i (dbg_addr_i),
    .rd_data_o (dbg_data_o)
  );

  assign dout_en_o = cs_s;
  assign dout_o    = cs_s & ~busy;
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk #(
  parameter int AW     = 6,
  parameter int T_PROG = 300
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_s_i,
  input logic          busy_i,
  input logic          wen_i,
  input logic          dout_i,
  input logic          dout_en_i,
  input logic [AW-1:0] job_addr_i
);
  int unsigned busy_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt <= 0;
    else if (busy_i) busy_cnt <= busy_cnt + 1;
    else busy_cnt <= 0;
  end

  assert_busy_len_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_i) |-> busy_cnt == T_PROG);
  assert_busy_max_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> busy_cnt < T_PROG);
  assert_start_on_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> (!$past(cs_s_i) && $past(cs_s_i, 2)));
  assert_wen_gate_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(wen_i));
  assert_status_busy_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_s_i && busy_i) |-> (dout_en_i && !dout_i));
  assert_hiz_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_s_i) |=> !dout_en_i);
  assert_job_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && $past(busy_i)) |-> $stable(job_addr_i));
endmodule

bind mw_eeprom mw_eeprom_chk #(.AW(AW), .T_PROG(T_PROG)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_s_i     (cs_s),
  .busy_i     (busy),
  .wen_i      (wen),
  .dout_i     (dout_o),
  .dout_en_i  (dout_en_o),
  .job_addr_i (job_addr)
);

// File: tb/test_mw_eeprom.sv
module test_mw_eeprom;
  localparam int T_PROG  = 300;
  localparam int T_CSMIN = 8;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        cs = 1'b0, sclk = 1'b0, din = 1'b0;
  logic        dout, dout_en, cs_short;
  logic [5:0]  dbg_addr = '0;
  logic [15:0] dbg_data;
  int          checks = 0, fails = 0, cyc = 0, fall_cyc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mw_eeprom #(.T_PROG(T_PROG), .T_CSMIN(T_CSMIN)) i_mw_eeprom (
    .clk_i(clk), .rst_ni, .cs_i(cs), .sclk_i(sclk), .din_i(din),
    .dout_o(dout), .dout_en_o(dout_en), .cs_short_o(cs_short),
    .dbg_addr_i(dbg_addr), .dbg_data_o(dbg_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    din = b; wait_n(2); sclk = 1'b1; wait_n(2); sclk = 1'b0;
  endtask

  task automatic send(input logic [1:0] op, input logic [5:0] a, input logic [15:0] d,
                      input bit with_data, input int lead0);
    cs = 1'b1; wait_n(3);
    for (int i = 0; i < lead0; i++) bit_out(1'b0);
    bit_out(1'b1);
    for (int i = 1; i >= 0; i--) bit_out(op[i]);
    for (int i = 5; i >= 0; i--) bit_out(a[i]);
    if (with_data) for (int i = 15; i >= 0; i--) bit_out(d[i]);
    wait_n(2);
    cs = 1'b0; fall_cyc = cyc;
    wait_n(20);
  endtask

  // raise select, wait for ready; returns cycles since select fell
  task automatic poll_ready(output int elapsed);
    cs = 1'b1;
    elapsed = -1;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (dout_en && dout) begin elapsed = cyc - fall_cyc; break; end
    end
    cs = 1'b0; wait_n(20);
  endtask

  task automatic read(input logic [5:0] a, output logic [15:0] d);
    dbg_addr = a; #1 d = dbg_data;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    read(6'd0, d);  check(d == 16'hFFFF, "R12 word0", d, 16'hFFFF);
    read(6'd63, d); check(d == 16'hFFFF, "R12 word63", d, 16'hFFFF);
    check(dout_en == 1'b0, "R12 dout_en", dout_en, 0);
    check(cs_short == 1'b0, "R12 cs_short", cs_short, 0);
  endtask

  task automatic t_disabled;
    logic [15:0] d;
    send(2'b01, 6'd2, 16'h1357, 1, 0);   // write while disabled
    cs = 1'b1; wait_n(4);
    check(dout_en && dout, "R10 no busy when disabled", {dout_en, dout}, 3);
    cs = 1'b0; wait_n(T_PROG + 20);
    read(6'd2, d); check(d == 16'hFFFF, "R10 word unchanged", d, 16'hFFFF);
    send(2'b00, 6'b110000, 16'h0, 0, 0); // enable
  endtask

  task automatic t_write;
    logic [15:0] d;
    int el;
    send(2'b01, 6'd5, 16'hA5A5, 1, 2);   // R13 leading zeros
    cs = 1'b1; wait_n(4);
    check(dout_en && !dout, "R2 busy after fall", {dout_en, dout}, 2);
    cs = 1'b0; wait_n(10);
    check(!dout_en, "R5 not driven while low", dout_en, 0);
    poll_ready(el);
    check(el >= T_PROG + 1 && el <= T_PROG + 5, "R4 cycle length", el, T_PROG + 3);
    read(6'd5, d); check(d == 16'hA5A5, "R1 R13 stored word", d, 16'hA5A5);
    send(2'b01, 6'd5, 16'h1234, 1, 0);
    wait_n(40);
    read(6'd5, d); check(d == 16'hFFFF, "R6 cleared mid-cycle", d, 16'hFFFF);
    poll_ready(el);
    read(6'd5, d); check(d == 16'h1234, "R6 R1 final data", d, 16'h1234);
  endtask

  task automatic t_busy_ignore;
    logic [15:0] d;
    int el;
    send(2'b01, 6'd3, 16'h1111, 1, 0);
    send(2'b01, 6'd4, 16'h2222, 1, 0);   // lands while busy
    poll_ready(el);
    read(6'd3, d); check(d == 16'h1111, "R11 first command", d, 16'h1111);
    read(6'd4, d); check(d == 16'hFFFF, "R11 second ignored", d, 16'hFFFF);
  endtask

  task automatic t_wral;
    logic [15:0] d;
    int el;
    send(2'b01, 6'd7, 16'h0F0F, 1, 0); poll_ready(el);
    send(2'b00, 6'b010000, 16'h3C3C, 1, 0);
    wait_n(40);
    read(6'd7, d); check(d == 16'h0F0F, "R9 no clear phase", d, 16'h0F0F);
    poll_ready(el);
    for (int a = 0; a < 64; a += 9) begin
      read(6'(a), d); check(d == 16'h3C3C, "R9 every word", d, 16'h3C3C);
    end
  endtask

  task automatic t_erase;
    logic [15:0] d;
    int el;
    send(2'b11, 6'd9, 16'h0, 0, 0); poll_ready(el);
    read(6'd9, d);  check(d == 16'hFFFF, "R7 erased word", d, 16'hFFFF);
    read(6'd10, d); check(d == 16'h3C3C, "R7 neighbour kept", d, 16'h3C3C);
    send(2'b00, 6'b100000, 16'h0, 0, 0); poll_ready(el);
    for (int a = 0; a < 64; a += 7) begin
      read(6'(a), d); check(d == 16'hFFFF, "R8 every word", d, 16'hFFFF);
    end
  endtask

  task automatic t_ewds;
    logic [15:0] d;
    send(2'b00, 6'b000000, 16'h0, 0, 0); // disable
    send(2'b11, 6'd1, 16'h0, 0, 0);      // cannot start anyway; then write
    send(2'b01, 6'd1, 16'h4444, 1, 0);
    cs = 1'b1; wait_n(4);
    check(dout_en && dout, "R10 disabled again", {dout_en, dout}, 3);
    cs = 1'b0; wait_n(T_PROG + 20);
    read(6'd1, d); check(d == 16'hFFFF, "R10 word unchanged after disable", d, 16'hFFFF);
  endtask

  task automatic t_cs_short;
    cs = 1'b1; wait_n(5);
    cs = 1'b0; wait_n(3);
    cs = 1'b1; wait_n(5);
    check(cs_short == 1'b1, "R3 short low flagged", cs_short, 1);
    cs = 1'b0; wait_n(5);
    check(cs_short == 1'b0, "R3 cleared on fall", cs_short, 0);
    wait_n(35);
    cs = 1'b1; wait_n(5);
    check(cs_short == 1'b0, "R3 long low clean", cs_short, 0);
    cs = 1'b0; wait_n(20);
  endtask

  initial begin
    wait_n(150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait_n(4);
    rst_ni = 1'b1;
    wait_n(4);
    t_reset();
    t_disabled();
    t_write();
    t_busy_ignore();
    t_wral();
    t_erase();
    t_ewds();
    t_cs_short();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule